// File: doc/BRIEF.md
# Display Identification I2C Target

This block is an I2C target that serves a fixed 128-byte display identification table to a bus controller. It samples SCL and SDA with the system clock, finds START, repeated START and STOP conditions, and answers at the 7-bit display-data address 0x50. It holds one 8-bit byte pointer. A controller sets the pointer by writing one byte. It then issues a repeated START and reads from that point on.

The target drives SDA open-drain only. The output `sda_oe` pulls the line low when high, and the bus pull-up supplies the high level. A finite state machine with eight states runs the bus protocol:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WR_BYTE`: shifting in a data byte.
- `ST_WR_ACK`: acknowledging a data byte.
- `ST_RD_BYTE`: shifting out a table byte.
- `ST_RD_ACK`: sampling the controller's acknowledge.
- `ST_SKIP`: ignoring the bus until the next condition.

The state transitions are:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a match or to `ST_SKIP` on a miss.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE`, as the R/W bit selects.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes to `ST_RD_BYTE` on ACK and to `ST_SKIP` on NACK.

Top module: `ddc_target`

## Requirements
- R1: The target acknowledges address byte 0x50 with either R/W bit (bus bytes 0xA0 write, 0xA1 read). For any other address it keeps SDA released, and ignores the bus until the next START or STOP.
- R2: A falling SDA while SCL is high (START) restarts address reception from any state. A rising SDA while SCL is high (STOP) returns the target to idle with SDA released. A byte cut short by a START has no effect on the pointer.
- R3: The first data byte after an acknowledged write address is loaded into the pointer and is acknowledged.
- R4: Every later written byte is acknowledged and not stored, and it advances the pointer by one.
- R5: Each read byte is table[pointer mod 128], and the pointer then increments. The 8-bit pointer wraps from 255 to 0.
- R6: The pointer keeps its value across a repeated START, so a pointer write followed by a read starts at the written value.
- R7: A NACK from the controller after a read byte ends the transfer. SDA stays released until the next START, and the pointer advances only for the bytes actually sent.
- R8: After reset the pointer is 0, the first-byte flag is clear and SDA is released.
- R9: The target changes `sda_oe` only while SCL is low.
- R10: Table bytes 0 to 7 are 00, FF, FF, FF, FF, FF, FF, 00. Byte i for 8 ≤ i ≤ 126 is (37·i + 11) mod 256. Byte 127 makes the sum of all 128 bytes 0 mod 256.
- R11: Read bytes go out most significant bit first, with `sda_oe` high meaning SDA pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The closest coincidence in this block is a pointer update from a completed written byte against a bus condition that follows at once. The update lands on the eighth falling SCL edge, and a START can come right after the acknowledge. The bench issues a repeated START directly after each pointer write and checks that the first read byte comes from the written pointer. It also aborts a written byte three bits in with a START and checks that the pointer did not move. A STOP arriving while the target is idle or skipping is judged by SDA staying released.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } ddc_state_e;

    // Table byte for every index except the final checksum byte.
    function automatic logic [7:0] id_raw(int unsigned idx);
        if (idx == 0 || idx == 7) return 8'h00;
        if (idx < 7) return 8'hFF;
        return 8'((idx * 37 + 11) % 256);
    endfunction

    // Value that makes the whole table sum to zero modulo 256.
    function automatic logic [7:0] id_checksum(int unsigned depth);
        logic [7:0] acc;
        acc = 8'h00;
        for (int unsigned k = 0; k < depth - 1; k++) begin
            acc = acc + id_raw(k);
        end
        return 8'(8'h00 - acc);
    endfunction

endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ddc_cond.sv
module ddc_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/ddc_rom.sv
module ddc_rom #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);

    localparam logic [7:0] CKSUM = ddc_pkg::id_checksum(DEPTH);

    always_comb begin
        if (32'(addr) == DEPTH - 1) data = CKSUM;
        else                        data = ddc_pkg::id_raw(32'(addr));
    end

endmodule

// File: rtl/ddc_target.sv
module ddc_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         SYNC_STAGES = 2,
    parameter int         BUF_BYTES   = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import ddc_pkg::*;

    localparam int IDX_W = $clog2(BUF_BYTES);
    localparam int PTR_W = 8;
    localparam logic [3:0] BITS_DONE = 4'd8;

    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;
    logic [1:0] sync_q;

    ddc_state_e state, state_nx;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [PTR_W-1:0] ptr;
    logic             first_q;
    logic             ack_q;
    logic [7:0]       rom_q;
    logic             addr_hit;
    logic             byte_end;

    ddc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    ddc_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    ddc_rom #(.DEPTH(BUF_BYTES), .AW(IDX_W)) u_rom (
        .addr (ptr[IDX_W-1:0]),
        .data (rom_q)
    );

    assign addr_hit = (rx_sh[7:1] == DEV_ADDR);
    assign byte_end = scl_fall && (bit_cnt == BITS_DONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        if (start_ev) begin
            state_nx = ST_ADDR;
        end else if (stop_ev) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_end) state_nx = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_nx = rx_sh[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_end) state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_end) state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_nx = ack_q ? ST_RD_BYTE : ST_SKIP;
                ST_SKIP:     state_nx = ST_SKIP;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            first_q <= 1'b0;
            ack_q   <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_SKIP: begin
                    sda_oe <= 1'b0;
                end
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_hit) begin
                                sda_oe <= 1'b1;
                                if (!rx_sh[0]) first_q <= 1'b1;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            if (first_q) begin
                                ptr     <= rx_sh;
                                first_q <= 1'b0;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rx_sh[0]) begin
                            tx_sh  <= rom_q;
                            sda_oe <= ~rom_q[7];
                            ptr    <= ptr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                    end else if (scl_fall && bit_cnt != 4'd0) begin
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                        sda_oe <= ~tx_sh[6];
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ack_q <= ~sda_s;
                    end else if (scl_fall) begin
                        bit_cnt <= '0;
                        if (ack_q) begin
                            tx_sh  <= rom_q;
                            sda_oe <= ~rom_q[7];
                            ptr    <= ptr + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ddc_target_chk.sv
module ddc_target_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                start_ev,
    input logic                stop_ev,
    input logic                sda_oe,
    input ddc_pkg::ddc_state_e state
);
    import ddc_pkg::*;

    // R9
    oe_hold_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R1
    skip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe);

    // R7
    ctrl_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK) |-> !sda_oe);

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_IDLE) || !sda_oe);

endmodule

bind ddc_target ddc_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .state    (state)
);

// File: tb/ddc_target_test.sv
module ddc_target_test;

    localparam int Q        = 8;
    localparam int WATCHDOG = 190000;
    localparam int NVEC     = 6;
    // {start pointer, bytes to read}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'd5,   8'd3},
        {8'd126, 8'd4},
        {8'd200, 8'd3},
        {8'd255, 8'd2},
        {8'd127, 8'd2},
        {8'd64,  8'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic bus_sda;
    int   n_tests = 0;
    int   n_fail  = 0;
    int   r9_viol = 0;
    bit   done    = 1'b0;

    always #5 clk = ~clk;

    assign bus_sda = sda_m & ~sda_oe;

    ddc_target uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (bus_sda),
        .sda_oe (sda_oe)
    );

    function automatic logic [7:0] tbl(int unsigned idx);
        logic [7:0] s;
        if (idx == 127) begin
            s = 8'h00;
            for (int unsigned k = 0; k < 127; k++) s = s + tbl(k);
            return 8'(8'h00 - s);
        end
        if (idx == 0 || idx == 7) return 8'h00;
        if (idx < 7) return 8'hFF;
        return 8'((idx * 37 + 11) % 256);
    endfunction

    function automatic logic [7:0] at_ptr(int unsigned p);
        return tbl((p % 256) % 128);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitq(Q);
            scl_m = 1'b1; waitq(2 * Q);
            scl_m = 1'b0; waitq(Q);
        end
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        acked = ~bus_sda;
        waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic rd_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitq(Q);
            scl_m = 1'b1; waitq(Q);
            b[i] = bus_sda;
            waitq(Q);
            scl_m = 1'b0; waitq(Q);
        end
        sda_m = nack; waitq(Q);
        scl_m = 1'b1; waitq(2 * Q);
        scl_m = 1'b0; waitq(Q);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p, input string req);
        bit a;
        bus_start();
        wr_byte(8'hA0, a);
        check(a, "R1", a, 1);
        wr_byte(p, a);
        check(a, req, a, 1);
    endtask

    // R9 monitor: sda_oe must not move while SCL stays high
    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) r9_viol++;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit         a;
        logic [7:0] b;
        logic [7:0] sum;

        waitq(4);
        rst_n = 1'b1;
        waitq(4);

        // R8: SDA released after reset
        check(sda_oe == 1'b0, "R8", sda_oe, 0);

        // R8: pointer starts at 0; read without pointer write
        bus_start();
        wr_byte(8'hA1, a);
        check(a, "R1", a, 1);
        rd_byte(1'b0, b);
        check(b == tbl(0), "R8", b, tbl(0));
        rd_byte(1'b1, b);
        check(b == tbl(1), "R11", b, tbl(1));
        bus_stop();

        // Vector table: pointer write, repeated START, sequential reads (R3, R5, R6)
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] p;
            int         n;
            p = VEC[v][15:8];
            n = int'(VEC[v][7:0]);
            set_ptr(p, "R3");
            bus_start();
            wr_byte(8'hA1, a);
            check(a, "R6", a, 1);
            for (int i = 0; i < n; i++) begin
                rd_byte(i == n - 1, b);
                check(b == at_ptr(int'(p) + i), "R5", b, at_ptr(int'(p) + i));
            end
            bus_stop();
        end

        // R1: foreign address gets no acknowledge, data ignored
        bus_start();
        wr_byte(8'hA2, a);
        check(!a, "R1", a, 0);
        wr_byte(8'h00, a);
        check(!a, "R1", a, 0);
        bus_stop();
        check(bus_sda == 1'b1, "R2", bus_sda, 1);

        // R4: extra written bytes acked, discarded, advance pointer
        set_ptr(8'd10, "R3");
        wr_byte(8'h33, a); check(a, "R4", a, 1);
        wr_byte(8'h44, a); check(a, "R4", a, 1);
        wr_byte(8'h55, a); check(a, "R4", a, 1);
        bus_stop();
        bus_start();
        wr_byte(8'hA1, a);
        rd_byte(1'b1, b);
        check(b == tbl(13), "R4", b, tbl(13));
        bus_stop();
        set_ptr(8'd11, "R3");
        bus_start();
        wr_byte(8'hA1, a);
        rd_byte(1'b1, b);
        check(b == tbl(11), "R4", b, tbl(11));
        bus_stop();

        // R7: NACK ends transfer, SDA released afterwards
        set_ptr(8'd20, "R3");
        bus_start();
        wr_byte(8'hA1, a);
        rd_byte(1'b1, b);
        check(b == tbl(20), "R7", b, tbl(20));
        begin
            int low_seen;
            low_seen = 0;
            for (int i = 0; i < 9; i++) begin
                waitq(Q);
                scl_m = 1'b1; waitq(Q);
                if (!bus_sda) low_seen++;
                waitq(Q);
                scl_m = 1'b0; waitq(Q);
            end
            check(low_seen == 0, "R7", low_seen, 0);
        end
        bus_stop();
        bus_start();
        wr_byte(8'hA1, a);
        rd_byte(1'b1, b);
        check(b == tbl(21), "R7", b, tbl(21));
        bus_stop();

        // R2: START aborting a written byte leaves the pointer alone
        set_ptr(8'd40, "R3");
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b0; waitq(Q);
            scl_m = 1'b1; waitq(2 * Q);
            scl_m = 1'b0; waitq(Q);
        end
        bus_start();
        wr_byte(8'hA1, a);
        check(a, "R2", a, 1);
        rd_byte(1'b1, b);
        check(b == tbl(40), "R2", b, tbl(40));
        bus_stop();

        // R10: full table and its checksum
        set_ptr(8'd0, "R3");
        bus_start();
        wr_byte(8'hA1, a);
        sum = 8'h00;
        for (int i = 0; i < 128; i++) begin
            rd_byte(i == 127, b);
            sum = sum + b;
            if (b != tbl(i)) check(1'b0, "R10", b, tbl(i));
        end
        bus_stop();
        check(sum == 8'h00, "R10", sum, 0);

        // R9: no drive change while SCL high over the whole run
        check(r9_viol == 0, "R9", r9_viol, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule